// File: doc/BRIEF.md
# Four-Lane Vector Register ALU

This block keeps three vector registers. Each register holds four signed lanes of 24 bits. The block runs lane-wise add, subtract, multiply and divide between two of those registers. A caller pulses `start_i` with an operation code and two register numbers, called source-one and source-two. The block latches the command, works out all four lanes in parallel in the next cycle, commits the whole result in one step and pulses `done_o`. A divide that meets a zero divisor in any lane raises `err_o` together with `done_o`, and it leaves every register as it was.

A side port writes or reads a whole register. A load unit uses it to fill registers, and a store unit or a test harness uses it to read results back. The block fetches no instructions and touches no memory.

Top module: `vec_alu`

## Requirements
- R1: Lane i of a register occupies bits [24*i+23 : 24*i]. Every lane result is reduced to its low 24 bits before it is written.
- R2: Register number 0 selects register A, 4 selects register S and 5 selects register T. A command that names any other number in either field writes nothing and raises no error, but `done_o` still pulses. A side read of such a number returns zero.
- R3: Operation code 0 (add) writes source-one + source-two, lane by lane, into source-two.
- R4: Operation code 2 (multiply) writes the low 24 bits of source-one × source-two, lane by lane, into source-two.
- R5: Operation code 1 (subtract) writes source-two − source-one, lane by lane, into source-two.
- R6: Operation code 3 (divide) writes source-two / source-one into register T, whatever source-two is. The division is signed and truncates toward zero.
- R7: If any divisor lane of a divide is zero, `err_o` pulses together with `done_o` and no lane of any register changes.
- R8: `done_o` is a one-cycle pulse. It is high in the second cycle after the clock edge that samples an accepted `start_i`.
- R9: A `start_i` that arrives while a command is in progress is ignored. It produces no second `done_o` and no register change.
- R10: A side write with `wr_en_i` replaces a whole register at the next edge. `rd_data_o` shows the register chosen by `rd_sel_i` with no delay. A side write in the cycle a command commits is dropped.
- R11: After reset all registers read zero, and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 2 | Operation code: 0 add, 1 sub, 2 mul, 3 div |
| r1_i | input | 4 | Source-one register number |
| r2_i | input | 4 | Source-two register number |
| done_o | output | 1 | Command finished, one-cycle pulse |
| err_o | output | 1 | Zero divisor detected, pulses with done_o |
| wr_en_i | input | 1 | Side write enable |
| wr_sel_i | input | 4 | Side write register number |
| wr_data_i | input | 96 | Side write data, four lanes |
| rd_sel_i | input | 4 | Side read register number |
| rd_data_o | output | 96 | Side read data, four lanes |

## Verification
Corrupt state in this block always shows up at `rd_data_o` or at the done and error pulses within two cycles of a command. A wrong register decode sends a result to the wrong register or writes to a register number that has none. A swapped operand order changes the sign of subtract results and the value of divide results. A missing zero-divisor gate shows as a T register changed by a failed divide. Busy tracking that never clears shows as a missing `done_o` two cycles after a start pulse. Busy tracking that lets a start through shows as an extra pulse or a second register update.

// File: rtl/vec_alu_pkg.sv
package vec_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } vop_e;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_A = 4'd0;
  localparam logic [SEL_W-1:0] SEL_S = 4'd4;
  localparam logic [SEL_W-1:0] SEL_T = 4'd5;

  localparam logic [1:0] SLOT_A    = 2'd0;
  localparam logic [1:0] SLOT_S    = 2'd1;
  localparam logic [1:0] SLOT_T    = 2'd2;
  localparam logic [1:0] SLOT_NONE = 2'd3;

  // sparse register number -> dense slot
  function automatic logic [1:0] sel_slot(input logic [SEL_W-1:0] s);
    case (s)
      SEL_A:   return SLOT_A;
      SEL_S:   return SLOT_S;
      SEL_T:   return SLOT_T;
      default: return SLOT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vec_lane_op.sv
module vec_lane_op
  import vec_alu_pkg::*;
#(
  parameter int W = 24
) (
  input  vop_e         op_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic [2*W-1:0]  prod;
  logic [W-1:0]    dvs;
  logic signed [W-1:0] quo;

  always_comb begin
    zero_o = (src1_i == '0);
    prod   = {{W{1'b0}}, src1_i} * {{W{1'b0}}, src2_i};
    dvs    = zero_o ? {{(W-1){1'b0}}, 1'b1} : src1_i;
    quo    = $signed(src2_i) / $signed(dvs);
    unique case (op_i)
      OP_ADD: res_o = src2_i + src1_i;
      OP_SUB: res_o = src2_i - src1_i;
      OP_MUL: res_o = prod[W-1:0];
      OP_DIV: res_o = quo;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int VW = 96
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    wslot_i,
  input  logic [VW-1:0] wdata_i,
  input  logic [1:0]    slot_a_i,
  output logic [VW-1:0] data_a_o,
  input  logic [1:0]    slot_b_i,
  output logic [VW-1:0] data_b_o,
  input  logic [1:0]    slot_c_i,
  output logic [VW-1:0] data_c_o
);
  localparam int NREG = 3;

  logic [VW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && wslot_i == 2'(g))    regs_q[g] <= wdata_i;
    end
  end

  function automatic logic [VW-1:0] pick(input logic [1:0] s);
    case (s)
      2'd0:    return regs_q[0];
      2'd1:    return regs_q[1];
      2'd2:    return regs_q[2];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    data_a_o = pick(slot_a_i);
    data_b_o = pick(slot_b_i);
    data_c_o = pick(slot_c_i);
  end
endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vec_alu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  vop_e             op_i,
  input  logic [SEL_W-1:0] r1_i,
  input  logic [SEL_W-1:0] r2_i,
  input  logic             fault_i,
  output logic             busy_o,
  output vop_e             op_o,
  output logic [SEL_W-1:0] r1_o,
  output logic [SEL_W-1:0] r2_o,
  output logic             done_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      op_o   <= OP_ADD;
      r1_o   <= '0;
      r2_o   <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= busy_o;
      err_o  <= busy_o & fault_i;
      if (busy_o) begin
        busy_o <= 1'b0;
      end else if (start_i) begin
        busy_o <= 1'b1;
        op_o   <= op_i;
        r1_o   <= r1_i;
        r2_o   <= r2_i;
      end
    end
  end
endmodule

// File: rtl/vec_alu.sv
module vec_alu
  import vec_alu_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 24,
  localparam int VW    = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [3:0]    r1_i,
  input  logic [3:0]    r2_i,
  output logic          done_o,
  output logic          err_o,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_sel_i,
  input  logic [VW-1:0] wr_data_i,
  input  logic [3:0]    rd_sel_i,
  output logic [VW-1:0] rd_data_o
);
  logic             busy;
  vop_e             op_q;
  logic [SEL_W-1:0] r1_q, r2_q;
  logic [1:0]       slot1, slot2, dslot, wslot, side_slot;
  logic [VW-1:0]    src1, src2, res, wdata;
  logic [LANES-1:0] zero;
  logic             ops_ok, div_fault, alu_we, we;

  vec_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (vop_e'(op_i)),
    .r1_i    (r1_i),
    .r2_i    (r2_i),
    .fault_i (div_fault),
    .busy_o  (busy),
    .op_o    (op_q),
    .r1_o    (r1_q),
    .r2_o    (r2_q),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vec_lane_op #(.W(LANE_W)) u_op (
      .op_i   (op_q),
      .src1_i (src1[g*LANE_W +: LANE_W]),
      .src2_i (src2[g*LANE_W +: LANE_W]),
      .res_o  (res[g*LANE_W +: LANE_W]),
      .zero_o (zero[g])
    );
  end

  always_comb begin
    slot1     = sel_slot(r1_q);
    slot2     = sel_slot(r2_q);
    side_slot = sel_slot(wr_sel_i);
    ops_ok    = (slot1 != SLOT_NONE) && (slot2 != SLOT_NONE);
    // any zero lane vetoes the whole divide
    div_fault = ops_ok && (op_q == OP_DIV) && (|zero);
    alu_we    = busy && ops_ok && !div_fault;
    dslot     = (op_q == OP_DIV) ? SLOT_T : slot2;
    // command commit owns the write port while busy
    we        = busy ? alu_we : (wr_en_i && side_slot != SLOT_NONE);
    wslot     = busy ? dslot : side_slot;
    wdata     = busy ? res : wr_data_i;
  end

  vec_regfile #(.VW(VW)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .wslot_i  (wslot),
    .wdata_i  (wdata),
    .slot_a_i (slot1),
    .data_a_o (src1),
    .slot_b_i (slot2),
    .data_b_o (src2),
    .slot_c_i (sel_slot(rd_sel_i)),
    .data_c_o (rd_data_o)
  );
endmodule

// File: rtl/vec_alu_chk.sv
module vec_alu_chk #(
  parameter int VW = 96
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic          err_o,
  input logic [3:0]    rd_sel_i,
  input logic [VW-1:0] rd_data_o,
  input logic          busy
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |-> ##2 done_o);

  // R9
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));

  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R7
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $stable(rd_sel_i)) |-> $stable(rd_data_o));
endmodule

bind vec_alu vec_alu_chk #(.VW(LANES * LANE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .err_o     (err_o),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .busy      (busy)
);

// File: tb/sim_vec_alu.sv
module sim_vec_alu;
  localparam int VW = 96;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [3:0]    r1_i = '0, r2_i = '0;
  logic          done_o, err_o;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_sel_i = '0;
  logic [VW-1:0] wr_data_i = '0;
  logic [3:0]    rd_sel_i = '0;
  logic [VW-1:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  vec_alu u0 (.*);

  function automatic logic [VW-1:0] pk(input logic [23:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  typedef struct packed {
    logic [1:0]    op;
    logic [3:0]    r1;
    logic [3:0]    r2;
    logic [VW-1:0] s1;
    logic [VW-1:0] s2;
    logic [VW-1:0] exp;
    logic          err;
  } vec_t;

  localparam logic [VW-1:0] SENT = {4{24'h5A5A5A}};
  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    // R3 add
    '{2'd0, 4'd0, 4'd4, pk(1,2,3,4), pk(5,6,7,8), pk(6,8,10,12), 1'b0},
    // R1 R3 add wrap
    '{2'd0, 4'd4, 4'd5, pk(24'h7FFFFF,24'hFFFFFF,24'h1,24'h800000),
      pk(1,1,24'hFFFFFF,24'h800000), pk(24'h800000,0,0,0), 1'b0},
    // R5 sub order
    '{2'd1, 4'd0, 4'd5, pk(3,10,0,1), pk(10,3,0,0), pk(7,24'hFFFFF9,0,24'hFFFFFF), 1'b0},
    // R4 mul low bits
    '{2'd2, 4'd5, 4'd0, pk(3,24'hFFFFFE,24'h1000,24'hFFFFFF),
      pk(7,5,24'h1000,24'hFFFFFF), pk(24'h15,24'hFFFFF6,0,1), 1'b0},
    // R6 div into T, r2 is A
    '{2'd3, 4'd4, 4'd0, pk(3,3,24'hFFFFFD,24'hFFFFFF),
      pk(7,24'hFFFFF9,7,9), pk(2,24'hFFFFFE,24'hFFFFFE,24'hFFFFF7), 1'b0},
    // R7 zero divisor lane
    '{2'd3, 4'd0, 4'd4, pk(1,2,0,4), pk(9,9,9,9), SENT, 1'b1},
    // R6 div with r2 = T
    '{2'd3, 4'd0, 4'd5, pk(2,24'hFFFFFE,5,1),
      pk(9,9,24'hFFFFFB,24'hFFFFFA), pk(4,24'hFFFFFC,24'hFFFFFF,24'hFFFFFA), 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [VW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, output logic [VW-1:0] d);
    rd_sel_i = sel;
    #1 d = rd_data_o;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b,
                        output logic d, output logic e);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; r1_i = a; r2_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    d = done_o; e = err_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] v, va0, vs0;
    logic d, e;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(done_o == 1'b0 && err_o == 1'b0, "R11 flags", {94'd0, done_o, err_o}, '0);
    rd(4'd0, v); chk(v == '0, "R11 A", v, '0);
    rd(4'd4, v); chk(v == '0, "R11 S", v, '0);
    rd(4'd5, v); chk(v == '0, "R11 T", v, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] dst;
      wr(4'd5, SENT);
      wr(TBL[i].r1, TBL[i].s1);
      wr(TBL[i].r2, TBL[i].s2);
      run_op(TBL[i].op, TBL[i].r1, TBL[i].r2, d, e);
      chk(d == 1'b1, $sformatf("R8 done vec%0d", i), {95'd0, d}, 1);
      chk(e == TBL[i].err, $sformatf("R7 err vec%0d", i), {95'd0, e}, {95'd0, TBL[i].err});
      dst = (TBL[i].op == 2'd3) ? 4'd5 : TBL[i].r2;
      rd(dst, v);
      chk(v == TBL[i].exp, $sformatf("R1 R3 R4 R5 R6 result vec%0d", i), v, TBL[i].exp);
      @(negedge clk_i);
      chk(done_o == 1'b0, $sformatf("R8 pulse vec%0d", i), {95'd0, done_o}, 0);
    end

    // R2 invalid r2 number: no write, no error
    wr(4'd0, pk(1,2,3,4));
    wr(4'd4, pk(5,6,7,8));
    run_op(2'd0, 4'd0, 4'd3, d, e);
    chk(d == 1'b1 && e == 1'b0, "R2 invalid done/err", {94'd0, d, e}, 2);
    rd(4'd4, v); chk(v == pk(5,6,7,8), "R2 S kept", v, pk(5,6,7,8));
    rd(4'd0, v); chk(v == pk(1,2,3,4), "R2 A kept", v, pk(1,2,3,4));
    rd(4'd3, v); chk(v == '0, "R2 read invalid", v, '0);

    // R2 invalid divisor register: no error, T kept
    wr(4'd5, SENT);
    run_op(2'd3, 4'd2, 4'd0, d, e);
    chk(e == 1'b0, "R2 div invalid err", {95'd0, e}, 0);
    rd(4'd5, v); chk(v == SENT, "R2 T kept", v, SENT);

    // R9 second start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd0; r1_i = 4'd0; r2_i = 4'd4;
    @(negedge clk_i);
    op_i = 2'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9 first done", {95'd0, done_o}, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 no second done", {95'd0, done_o}, 0);
    rd(4'd4, v); chk(v == pk(6,8,10,12), "R9 S result", v, pk(6,8,10,12));

    // R10 side write during commit cycle is dropped
    wr(4'd4, pk(5,6,7,8));
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd0; r1_i = 4'd0; r2_i = 4'd4;
    @(negedge clk_i);
    start_i = 1'b0;
    wr_en_i = 1'b1; wr_sel_i = 4'd0; wr_data_i = {4{24'hABCDEF}};
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(4'd0, v); chk(v == pk(1,2,3,4), "R10 A not overwritten", v, pk(1,2,3,4));
    rd(4'd4, v); chk(v == pk(6,8,10,12), "R10 S result", v, pk(6,8,10,12));
    // R10 side write when idle
    wr(4'd0, {4{24'h123456}});
    rd(4'd0, v); chk(v == {4{24'h123456}}, "R10 idle write", v, {4{24'h123456}});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule